// File: doc/BRIEF.md
# Power-Fail Write-Protect Bus Gate

This block sits between an asynchronous SRAM-style bus (active-low chip enable, write enable and output enable, plus address and write data) and an internal memory or register array. It decodes read and write cycles from the three strobes and produces a read enable and a one-cycle write commit strobe toward the array. It also produces the enable for the three-state data drivers. The bus strobes are expected to be already in the block's clock domain. The supply-status input comes from an analog detector and is brought in through a synchronizer.

When the supply falls out of tolerance, the gate lets any qualified access that is under way run to its end. After that, it shuts the bus off completely: no reads, no writes and no data drive. An access that will not end is cut off after a parameterised number of cycles and is discarded. When the supply comes back, the gate pulses a clear for the interrupt-enable bits and keeps writes locked out for a parameterised recovery count. Reads are allowed during that count. It then returns to normal operation. A status output reports write protection, and a second one reports full deselection.

Top module: `pfg_bus_gate`

## Requirements
- R1: With the gate in normal operation, a read that starts with chip enable and output enable both low (write enable high) raises `mem_rd_en` and `dq_drive_en` from the second clock of the request. Both drop as soon as either strobe returns high.
- R2: Whenever write enable is low, `dq_drive_en` is low, even while chip enable and output enable are low.
- R3: A write request is chip enable low together with write enable low. It starts at the later of the two falling edges. When it ends at the first rising edge, `mem_wr_stb` is high for exactly one cycle. During that cycle, `mem_addr`/`mem_wdata` carry the address and data sampled on the last clock of the request.
- R4: If the synchronized supply drops while a qualified access is under way, that access still completes: a write still produces its strobe. `wr_protect` is already high at that point, and `bus_blocked` stays low until the access ends.
- R5: While `bus_blocked` is high, `mem_rd_en`, `dq_drive_en` and `mem_wr_stb` all stay low, whatever the bus does. An idle gate becomes blocked at the third clock after the supply input falls.
- R6: An access still running `DRAIN_LIMIT` cycles after the drain began is cut off: `xfer_abort` pulses in the last drain cycle, no write strobe follows, and the gate becomes blocked.
- R7: After power returns, `wr_protect` stays high for exactly `RECOVER_CYCLES` cycles, counted from the `ien_clr` pulse. Writes requested in that window never strobe, while reads are served.
- R8: `ien_clr` is a single-cycle pulse at the start of each recovery, including the first one after reset.
- R9: A write request that rose while writes were not allowed stays ignored for its whole length, even if protection lifts during it. Only a fresh request is accepted.
- R10: On reset the gate is deselected: `bus_blocked` and `wr_protect` are high, and `ien_clr`, `mem_wr_stb`, `mem_rd_en` and `dq_drive_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Bus chip enable, active low |
| bus_we_n | input | 1 | Bus write enable, active low |
| bus_oe_n | input | 1 | Bus output enable, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | DATA_W | Bus write data |
| supply_ok | input | 1 | Supply within tolerance (asynchronous) |
| mem_addr | output | ADDR_W | Array address (captured address during a write) |
| mem_wdata | output | DATA_W | Captured write data |
| mem_wr_stb | output | 1 | One-cycle write commit to the array |
| mem_rd_en | output | 1 | Array read enable |
| dq_drive_en | output | 1 | Enable of the three-state data drivers |
| wr_protect | output | 1 | Writes are currently not accepted |
| bus_blocked | output | 1 | Bus fully deselected |
| ien_clr | output | 1 | Pulse clearing the interrupt enables |
| xfer_abort | output | 1 | Access forcibly terminated |

## Verification
On every cycle, the assertions check several safety properties. A blocked gate stays silent on all array and driver outputs. A write strobe always follows a cycle of real write request and never comes while protection is in force for new writes. An abort is never followed by a commit. The drain counter stays within its limit. Normal operation is reached only through recovery, and the interrupt-enable clear is a single pulse after the deselected state. The bench scenarios cover the behaviours that depend on timing and sequence. These are the exact drain and recovery lengths, the completion of a write caught by a supply drop, data capture at the end of the write, and the rejection of a request that started while protected.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  typedef enum logic [1:0] {
    PW_RUN     = 2'd0,
    PW_DRAIN   = 2'd1,
    PW_OFF     = 2'd2,
    PW_RECOVER = 2'd3
  } pw_state_e;
endpackage

// File: rtl/pfg_supply_sync.sv
module pfg_supply_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sh_d = din;
    end else begin : g_chain
      always_comb sh_d = {sh_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/pfg_power_fsm.sv
module pfg_power_fsm
  import pfg_pkg::*;
#(
  parameter int DRAIN_LIMIT    = 64,
  parameter int RECOVER_CYCLES = 4096
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sup_ok,
  input  logic      busy,
  output pw_state_e state_q,
  output pw_state_e state_nxt,
  output logic      abort,
  output logic      ien_clr
);
  localparam int DCW = $clog2(DRAIN_LIMIT) + 1;
  localparam int RCW = $clog2(RECOVER_CYCLES) + 1;
  localparam logic [DCW-1:0] D_LAST = DCW'(DRAIN_LIMIT - 1);
  localparam logic [RCW-1:0] R_LOAD = RCW'(RECOVER_CYCLES - 1);

  logic [DCW-1:0] dcnt_q, dcnt_d;
  logic [RCW-1:0] rcnt_q, rcnt_d;
  logic           dcnt_en, rcnt_en;
  logic           ien_clr_d;
  logic           ien_clr_q;

  // next-state logic
  always_comb begin
    state_nxt = state_q;
    abort     = 1'b0;
    unique case (state_q)
      PW_RUN: begin
        if (!sup_ok) state_nxt = busy ? PW_DRAIN : PW_OFF;
      end
      PW_DRAIN: begin
        if (!busy) begin
          state_nxt = PW_OFF;
        end else if (dcnt_q == D_LAST) begin
          state_nxt = PW_OFF;
          abort     = 1'b1;
        end
      end
      PW_OFF: begin
        if (sup_ok) state_nxt = PW_RECOVER;
      end
      PW_RECOVER: begin
        if (!sup_ok)              state_nxt = busy ? PW_DRAIN : PW_OFF;
        else if (rcnt_q == '0)    state_nxt = PW_RUN;
      end
      default: state_nxt = PW_OFF;
    endcase
  end

  // counter next values with explicit enables
  always_comb begin
    dcnt_en = 1'b0;
    dcnt_d  = dcnt_q;
    if (state_q != PW_DRAIN && state_nxt == PW_DRAIN) begin
      dcnt_en = 1'b1;
      dcnt_d  = '0;
    end else if (state_q == PW_DRAIN && state_nxt == PW_DRAIN) begin
      dcnt_en = 1'b1;
      dcnt_d  = dcnt_q + 1'b1;
    end

    rcnt_en = 1'b0;
    rcnt_d  = rcnt_q;
    if (state_q == PW_OFF && state_nxt == PW_RECOVER) begin
      rcnt_en = 1'b1;
      rcnt_d  = R_LOAD;
    end else if (state_q == PW_RECOVER && rcnt_q != '0) begin
      rcnt_en = 1'b1;
      rcnt_d  = rcnt_q - 1'b1;
    end

    ien_clr_d = (state_q == PW_OFF) && (state_nxt == PW_RECOVER);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PW_OFF;
      dcnt_q    <= '0;
      rcnt_q    <= '0;
      ien_clr_q <= 1'b0;
    end else begin
      state_q   <= state_nxt;
      ien_clr_q <= ien_clr_d;
      if (dcnt_en) dcnt_q <= dcnt_d;
      if (rcnt_en) rcnt_q <= rcnt_d;
    end
  end

  assign ien_clr = ien_clr_q;

  // R6: the drain window never outlives its limit
  assert_drain_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PW_DRAIN) |-> (dcnt_q <= D_LAST));

  // R7: normal operation is entered only from itself or from recovery
  assert_run_via_recover_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PW_RUN) |-> ($past(state_q) == PW_RUN || $past(state_q) == PW_RECOVER));

  // R8: the clear pulse follows the deselected state and lasts one cycle
  assert_ien_after_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ien_clr |-> ($past(state_q) == PW_OFF && state_q == PW_RECOVER));
  assert_ien_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ien_clr |=> !ien_clr);
endmodule

// File: rtl/pfg_access_track.sv
module pfg_access_track
  import pfg_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  pw_state_e         state_q,
  input  pw_state_e         state_nxt,
  input  logic              abort,
  output logic              busy,
  output logic              wr_stb,
  output logic              rd_en,
  output logic              dq_en,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata
);
  logic              wr_req, rd_req;
  logic              wr_req_q, rd_req_q;
  logic              wr_live_q, wr_live_d;
  logic              rd_live_q, rd_live_d;
  logic              wr_ok_nxt, rd_ok_nxt;
  logic              cap_en;
  logic [ADDR_W-1:0] cap_addr_q;
  logic [DATA_W-1:0] cap_data_q;

  assign wr_req    = !ce_n && !we_n;
  assign rd_req    = !ce_n && !oe_n;
  assign wr_ok_nxt = (state_nxt == PW_RUN);
  assign rd_ok_nxt = (state_nxt == PW_RUN) || (state_nxt == PW_RECOVER);

  always_comb begin
    if (state_nxt == PW_OFF)  wr_live_d = 1'b0;
    else if (wr_live_q)       wr_live_d = wr_req;
    else                      wr_live_d = wr_req && !wr_req_q && wr_ok_nxt;

    if (state_nxt == PW_OFF)  rd_live_d = 1'b0;
    else if (rd_live_q)       rd_live_d = rd_req;
    else                      rd_live_d = rd_req && !rd_req_q && rd_ok_nxt;

    cap_en = wr_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_req_q   <= 1'b0;
      rd_req_q   <= 1'b0;
      wr_live_q  <= 1'b0;
      rd_live_q  <= 1'b0;
      cap_addr_q <= '0;
      cap_data_q <= '0;
    end else begin
      wr_req_q  <= wr_req;
      rd_req_q  <= rd_req;
      wr_live_q <= wr_live_d;
      rd_live_q <= rd_live_d;
      if (cap_en) begin
        cap_addr_q <= addr;
        cap_data_q <= wdata;
      end
    end
  end

  assign busy      = (wr_live_q && wr_req) || (rd_live_q && rd_req);
  assign wr_stb    = wr_live_q && !wr_req;
  assign rd_en     = rd_live_q && rd_req;
  assign dq_en     = rd_live_q && rd_req && we_n;
  assign arr_addr  = wr_live_q ? cap_addr_q : addr;
  assign arr_wdata = cap_data_q;

  // R3: a commit always follows a clock with a genuine write request
  assert_stb_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(!ce_n && !we_n));

  // R7: no commit while protection holds new writes off
  assert_no_stb_protected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (state_q == PW_RUN || state_q == PW_DRAIN));

  // R6: an aborted access is never committed afterwards
  assert_abort_no_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !wr_stb);

  // R2: data drivers off whenever write enable is low
  assert_dq_off_on_we_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !dq_en);
endmodule

// File: rtl/pfg_bus_gate.sv
module pfg_bus_gate
  import pfg_pkg::*;
#(
  parameter int ADDR_W         = 19,
  parameter int DATA_W         = 8,
  parameter int SYNC_STAGES    = 2,
  parameter int DRAIN_LIMIT    = 64,
  parameter int RECOVER_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic              bus_oe_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              supply_ok,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wr_stb,
  output logic              mem_rd_en,
  output logic              dq_drive_en,
  output logic              wr_protect,
  output logic              bus_blocked,
  output logic              ien_clr,
  output logic              xfer_abort
);
  logic      sup_ok_s;
  logic      busy;
  pw_state_e state_q;
  pw_state_e state_nxt;

  pfg_supply_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (supply_ok),
    .dout  (sup_ok_s)
  );

  pfg_power_fsm #(
    .DRAIN_LIMIT    (DRAIN_LIMIT),
    .RECOVER_CYCLES (RECOVER_CYCLES)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sup_ok    (sup_ok_s),
    .busy      (busy),
    .state_q   (state_q),
    .state_nxt (state_nxt),
    .abort     (xfer_abort),
    .ien_clr   (ien_clr)
  );

  pfg_access_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) trk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (bus_ce_n),
    .we_n      (bus_we_n),
    .oe_n      (bus_oe_n),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .state_q   (state_q),
    .state_nxt (state_nxt),
    .abort     (xfer_abort),
    .busy      (busy),
    .wr_stb    (mem_wr_stb),
    .rd_en     (mem_rd_en),
    .dq_en     (dq_drive_en),
    .arr_addr  (mem_addr),
    .arr_wdata (mem_wdata)
  );

  assign wr_protect  = (state_q != PW_RUN);
  assign bus_blocked = (state_q == PW_OFF);

  // R5: a deselected gate keeps every array and driver output quiet
  assert_blocked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_blocked |-> (!mem_rd_en && !dq_drive_en && !mem_wr_stb));

  // R4: deselection is never reached while a qualified access is still busy
  assert_no_cut_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_abort) |=> !bus_blocked);
endmodule

// File: tb/pfg_bus_gate_tb_top.sv
module pfg_bus_gate_tb_top;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int DLIM = 16;
  localparam int RCYC = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          sup = 1'b1;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata;
  logic          stb, rd_en, dq_en, prot, blk, iclr, abrt;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pfg_bus_gate #(
    .ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2),
    .DRAIN_LIMIT(DLIM), .RECOVER_CYCLES(RCYC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
    .bus_addr(addr), .bus_wdata(wdata), .supply_ok(sup),
    .mem_addr(m_addr), .mem_wdata(m_wdata), .mem_wr_stb(stb), .mem_rd_en(rd_en),
    .dq_drive_en(dq_en), .wr_protect(prot), .bus_blocked(blk), .ien_clr(iclr),
    .xfer_abort(abrt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic bus_idle();
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_run();
    for (int i = 0; i < 200 && prot; i++) step(1);
    chk("R7 reached normal operation", prot, 0);
  endtask

  task automatic power_cycle();
    sup = 1'b0;
    for (int i = 0; i < 200 && !blk; i++) step(1);
    sup = 1'b1;
    wait_run();
  endtask

  task automatic t_reset_and_recover();
    int n;
    #1;
    chk("R10 blocked in reset", blk, 1);
    chk("R10 protect in reset", prot, 1);
    chk("R10 no strobe in reset", stb, 0);
    chk("R10 no clear in reset", iclr, 0);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R10 blocked after reset", blk, 1);
    chk("R10 no drive after reset", dq_en + rd_en, 0);
    for (int i = 0; i < 20 && !iclr; i++) step(1);
    chk("R8 clear pulse after reset", iclr, 1);
    n = 0;
    while (prot && n < 200) begin n++; step(1); end
    chk("R7 recovery length", n, RCYC);
  endtask

  task automatic t_read();
    step(1);
    addr = 8'h3C; ce_n = 1'b0; oe_n = 1'b0; #1;
    chk("R1 read not yet", rd_en, 0);
    step(1);
    chk("R1 read enable", rd_en, 1);
    chk("R1 drive enable", dq_en, 1);
    chk("R1 read address", m_addr, 8'h3C);
    oe_n = 1'b1; #1;
    chk("R1 drop on OE high", rd_en + dq_en, 0);
    bus_idle(); step(2);
  endtask

  task automatic t_we_override();
    step(1);
    ce_n = 1'b0; oe_n = 1'b0; step(2);
    chk("R2 drive before WE", dq_en, 1);
    we_n = 1'b0; #1;
    chk("R2 WE low forces hi-Z", dq_en, 0);
    step(1);
    chk("R2 still hi-Z", dq_en, 0);
    bus_idle(); step(2);
  endtask

  task automatic t_write();
    int hits;
    step(1);
    addr = 8'h11; wdata = 8'hA5; ce_n = 1'b0; step(1);
    we_n = 1'b0; step(1);            // later falling edge starts the write
    addr = 8'h22; wdata = 8'h5A; step(1);
    chk("R3 no strobe mid-write", stb, 0);
    ce_n = 1'b1; addr = 8'h77; wdata = 8'hFF; #1;   // CE rises first
    chk("R3 strobe at end", stb, 1);
    chk("R3 captured address", m_addr, 8'h22);
    chk("R3 captured data", m_wdata, 8'h5A);
    hits = 0;
    for (int i = 0; i < 4; i++) begin step(1); hits += stb; end
    chk("R3 single strobe", hits, 0);
    bus_idle(); step(1);
  endtask

  task automatic t_drain_complete();
    step(1);
    addr = 8'h40; wdata = 8'h9C; ce_n = 1'b0; we_n = 1'b0; step(1);
    sup = 1'b0; step(4);
    chk("R4 protect during drain", prot, 1);
    chk("R4 not blocked during access", blk, 0);
    we_n = 1'b1; #1;
    chk("R4 write completes", stb, 1);
    chk("R4 completed data", m_wdata, 8'h9C);
    bus_idle(); step(1);
    chk("R5 blocked after drain", blk, 1);
  endtask

  task automatic t_blocked();
    int seen;
    seen = 0;
    ce_n = 1'b0; oe_n = 1'b0;
    for (int i = 0; i < 5; i++) begin step(1); seen += rd_en + dq_en; end
    oe_n = 1'b1; we_n = 1'b0;
    for (int i = 0; i < 5; i++) begin step(1); seen += stb; end
    bus_idle();
    for (int i = 0; i < 3; i++) begin step(1); seen += stb; end
    chk("R5 blocked ignores bus", seen, 0);
    chk("R5 still blocked", blk, 1);
    sup = 1'b1;
  endtask

  task automatic t_recover_rules();
    int hits;
    for (int i = 0; i < 20 && !iclr; i++) step(1);
    chk("R8 clear pulse on power-up", iclr, 1);
    step(1);
    chk("R8 clear is one cycle", iclr, 0);
    ce_n = 1'b0; oe_n = 1'b0; step(2);
    chk("R7 read served in recovery", rd_en, 1);
    bus_idle(); step(1);
    ce_n = 1'b0; we_n = 1'b0; wdata = 8'h33;
    hits = 0;
    for (int i = 0; i < RCYC + 4; i++) begin step(1); hits += stb; end
    chk("R9 protection lifted during request", prot, 0);
    we_n = 1'b1; #1; hits += stb;
    step(1); hits += stb;
    chk("R7 R9 write from recovery ignored", hits, 0);
    ce_n = 1'b1; step(1);
    ce_n = 1'b0; we_n = 1'b0; step(2);
    we_n = 1'b1; #1;
    chk("R9 fresh write accepted", stb, 1);
    bus_idle(); step(2);
  endtask

  task automatic t_idle_drop();
    int n;
    step(1);
    sup = 1'b0;
    n = 0;
    while (!blk && n < 20) begin step(1); n++; end
    chk("R5 idle deselect latency", n, 3);
    chk("R5 protect with blocked", prot, 1);
    sup = 1'b1; wait_run();
  endtask

  task automatic t_timeout();
    int n, hits;
    step(1);
    ce_n = 1'b0; we_n = 1'b0; wdata = 8'h66; step(1);
    sup = 1'b0;
    for (int i = 0; i < 10 && !prot; i++) step(1);
    n = 1;
    while (!abrt && n < 100) begin step(1); n++; end
    chk("R6 abort after drain limit", n, DLIM);
    hits = 0;
    step(1);
    chk("R6 blocked after abort", blk, 1);
    we_n = 1'b1; #1; hits += stb;
    step(2); hits += stb;
    chk("R6 no commit after abort", hits, 0);
    bus_idle(); sup = 1'b1; wait_run();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(3);
    t_reset_and_recover();
    t_read();
    t_we_override();
    t_write();
    t_drain_complete();
    t_blocked();
    t_recover_rules();
    t_idle_drop();
    t_timeout();
    power_cycle();
    t_write();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule